// File: doc/BRIEF.md
# Packet Batch Transfer Engine

This block moves one whole packet between a local dual-port byte buffer and a peripheral's auto-incrementing data port, with no processor in the loop. A start pulse picks the direction and the packet length. From then on the engine steps a byte counter that serves as the buffer address. For every byte it launches one bus cycle on a separate cycle generator and waits for that cycle to finish.

In the outbound direction the engine reads a byte from the buffer and hands it to the cycle generator as write data. In the inbound direction it takes the byte returned by a read cycle and writes it into the buffer. The peripheral register address is captured at start and held for the whole batch, because the peripheral moves its own internal pointer after each access. Only the local buffer address advances. A completion flag reports the end of the batch and stays set until the next batch is accepted.

Top module: `pkt_xfer_engine`

## Requirements
- R1: With `len_long`=1 at start a batch moves LONG_LEN bytes (default 512); with `len_long`=0 it moves SHORT_LEN bytes (default 256). It issues exactly that many `cyc_req` pulses.
- R2: The buffer address is cleared to 0 at each accepted start and rises by one per byte. An active-low `rst_n` clears it asynchronously and returns the engine to idle.
- R3: Outbound (`dir_in`=0): there is one `buf_rd_en` pulse per byte, at addresses 0,1,2,… in ascending order. The `cyc_wdata` of byte k equals the buffer byte at address k.
- R4: Outbound: `cyc_req` rises exactly two clocks after the matching `buf_rd_en`. That is one clock after the byte appears at the synchronous buffer output.
- R5: `cyc_addr` equals `reg_sel` as sampled at the accepted start. It does not change during the batch, whatever `reg_sel` does.
- R6: Outbound: the engine never asserts `buf_wr_en`. At most one of `buf_rd_en`, `buf_wr_en` and `cyc_req` is high in any cycle.
- R7: Inbound (`dir_in`=1): the `cyc_rdata` returned with the cycle-done pulse of byte k is written to buffer address k. `buf_wr_en` is high for one clock, one clock after that `cyc_done`.
- R8: `done` rises one clock after the last byte completes: after the final `cyc_done` when outbound, after the final buffer write when inbound. `busy` is then low. `done` holds until the next accepted start, which clears it.
- R9: A `start` pulse while `busy` is high is ignored. Length, direction and register address of the running batch are unaffected.
- R10: `cyc_wr` is 1 for an outbound batch and 0 for an inbound batch. `cyc_req` is a one-clock pulse per byte. No new `cyc_req` is issued before the `cyc_done` of the previous byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a batch (accepted only when idle) |
| len_long | input | 1 | 1 selects long packet, 0 short packet |
| dir_in | input | 1 | 1 peripheral-to-buffer, 0 buffer-to-peripheral |
| reg_sel | input | REG_W | Peripheral data-port register address |
| buf_addr | output | ADDR_W | Buffer byte address (byte counter) |
| buf_rd_en | output | 1 | Buffer read strobe (synchronous read) |
| buf_rdata | input | DATA_W | Buffer read data, valid one clock after `buf_rd_en` |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wdata | output | DATA_W | Buffer write data |
| cyc_req | output | 1 | Launch one peripheral bus cycle |
| cyc_wr | output | 1 | Bus cycle direction, 1 write |
| cyc_addr | output | REG_W | Peripheral register address for the cycle |
| cyc_wdata | output | DATA_W | Write data for the cycle |
| cyc_done | input | 1 | Bus cycle finished (one-clock pulse) |
| cyc_rdata | input | DATA_W | Read data, valid with `cyc_done` |
| busy | output | 1 | Batch in progress |
| done | output | 1 | Batch complete flag |

## Verification
The hardest situations to reach are the interaction of a running batch with inputs that must not disturb it, and an abort partway through a packet. The bench models the buffer and the cycle generator, with a bus-cycle latency of one to three clocks. In several batches it toggles `reg_sel` right after start and fires a second `start` with the other length and direction partway through. It then counts every strobe to show that nothing changed. One long outbound batch is cut by an asynchronous reset between clock edges, and the address and state are checked before the next edge arrives.

// File: rtl/pkt_xfer_pkg.sv
package pkt_xfer_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_ISSUE,
    ST_WAIT,
    ST_STORE
  } xfer_st_e;
endpackage

// File: rtl/pkt_byte_ctr.sv
module pkt_byte_ctr #(
  parameter int LONG_LEN  = 512,
  parameter int SHORT_LEN = 256,
  parameter int CNT_W     = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic             long_sel,
  output logic [CNT_W-1:0] cnt,
  output logic             carry
);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(LONG_LEN - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_LEN - 1);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // terminal count of the selected packet length
  always_comb begin
    carry = (cnt == (long_sel ? LAST_LONG : LAST_SHORT));
  end

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = clr ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_d;
    end
  end
endmodule

// File: rtl/pkt_xfer_seq.sv
module pkt_xfer_seq
  import pkt_xfer_pkg::*;
#(
  parameter int REG_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              len_long,
  input  logic              dir_in,
  input  logic [REG_W-1:0]  reg_sel,
  input  logic              carry,
  input  logic [DATA_W-1:0] buf_rdata,
  input  logic              cyc_done,
  input  logic [DATA_W-1:0] cyc_rdata,
  output logic              ctr_clr,
  output logic              ctr_inc,
  output logic              long_q,
  output logic              dir_q,
  output logic [REG_W-1:0]  reg_q,
  output logic [DATA_W-1:0] data_q,
  output logic              buf_rd_en,
  output logic              buf_wr_en,
  output logic              cyc_req,
  output logic              busy,
  output logic              done
);
  xfer_st_e          st_q, st_d;
  logic              done_d;
  logic              cfg_ld;
  logic              data_ld;
  logic [DATA_W-1:0] data_d;

  // next-state logic
  always_comb begin
    st_d    = st_q;
    done_d  = done;
    ctr_clr = 1'b0;
    ctr_inc = 1'b0;
    cfg_ld  = 1'b0;
    data_ld = 1'b0;
    data_d  = buf_rdata;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          cfg_ld  = 1'b1;
          ctr_clr = 1'b1;
          done_d  = 1'b0;
          st_d    = dir_in ? ST_ISSUE : ST_FETCH;
        end
      end
      ST_FETCH: st_d = ST_LOAD;
      ST_LOAD: begin
        data_ld = 1'b1;
        st_d    = ST_ISSUE;
      end
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT: begin
        if (cyc_done) begin
          if (dir_q) begin
            data_ld = 1'b1;
            data_d  = cyc_rdata;
            st_d    = ST_STORE;
          end else if (carry) begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            ctr_inc = 1'b1;
            st_d    = ST_FETCH;
          end
        end
      end
      ST_STORE: begin
        if (carry) begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          ctr_inc = 1'b1;
          st_d    = ST_ISSUE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    buf_rd_en = (st_q == ST_FETCH);
    buf_wr_en = (st_q == ST_STORE);
    cyc_req   = (st_q == ST_ISSUE);
    busy      = (st_q != ST_IDLE);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      done <= 1'b0;
    end else begin
      st_q <= st_d;
      done <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      long_q <= 1'b0;
      dir_q  <= 1'b0;
      reg_q  <= '0;
    end else if (cfg_ld) begin
      long_q <= len_long;
      dir_q  <= dir_in;
      reg_q  <= reg_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_ld) begin
      data_q <= data_d;
    end
  end
endmodule

// File: rtl/pkt_xfer_engine.sv
module pkt_xfer_engine #(
  parameter int LONG_LEN  = 512,
  parameter int SHORT_LEN = 256,
  parameter int REG_W     = 3,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = $clog2(LONG_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              len_long,
  input  logic              dir_in,
  input  logic [REG_W-1:0]  reg_sel,
  output logic [ADDR_W-1:0] buf_addr,
  output logic              buf_rd_en,
  input  logic [DATA_W-1:0] buf_rdata,
  output logic              buf_wr_en,
  output logic [DATA_W-1:0] buf_wdata,
  output logic              cyc_req,
  output logic              cyc_wr,
  output logic [REG_W-1:0]  cyc_addr,
  output logic [DATA_W-1:0] cyc_wdata,
  input  logic              cyc_done,
  input  logic [DATA_W-1:0] cyc_rdata,
  output logic              busy,
  output logic              done
);
  logic              ctr_clr, ctr_inc, carry, long_q, dir_q;
  logic [REG_W-1:0]  reg_q;
  logic [DATA_W-1:0] data_q;

  pkt_byte_ctr #(
    .LONG_LEN (LONG_LEN),
    .SHORT_LEN(SHORT_LEN),
    .CNT_W    (ADDR_W)
  ) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ctr_clr),
    .inc     (ctr_inc),
    .long_sel(long_q),
    .cnt     (buf_addr),
    .carry   (carry)
  );

  pkt_xfer_seq #(
    .REG_W (REG_W),
    .DATA_W(DATA_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .len_long (len_long),
    .dir_in   (dir_in),
    .reg_sel  (reg_sel),
    .carry    (carry),
    .buf_rdata(buf_rdata),
    .cyc_done (cyc_done),
    .cyc_rdata(cyc_rdata),
    .ctr_clr  (ctr_clr),
    .ctr_inc  (ctr_inc),
    .long_q   (long_q),
    .dir_q    (dir_q),
    .reg_q    (reg_q),
    .data_q   (data_q),
    .buf_rd_en(buf_rd_en),
    .buf_wr_en(buf_wr_en),
    .cyc_req  (cyc_req),
    .busy     (busy),
    .done     (done)
  );

  always_comb begin
    cyc_wr    = ~dir_q;
    cyc_addr  = reg_q;
    cyc_wdata = data_q;
    buf_wdata = data_q;
  end
endmodule

// File: rtl/pkt_xfer_engine_chk.sv
module pkt_xfer_engine_chk #(
  parameter int REG_W  = 3,
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] buf_addr,
  input logic              buf_rd_en,
  input logic              buf_wr_en,
  input logic              cyc_req,
  input logic              cyc_wr,
  input logic [REG_W-1:0]  cyc_addr,
  input logic              busy,
  input logic              done
);
  assert_req_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_en |-> ##2 cyc_req);

  assert_no_write_outbound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cyc_wr) |-> !buf_wr_en);

  assert_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({buf_rd_en, buf_wr_en, cyc_req}));

  assert_reg_addr_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cyc_addr));

  assert_addr_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (buf_addr == '0));

  assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_req_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_req |=> !cyc_req);
endmodule

bind pkt_xfer_engine pkt_xfer_engine_chk #(
  .REG_W (REG_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .buf_addr (buf_addr),
  .buf_rd_en(buf_rd_en),
  .buf_wr_en(buf_wr_en),
  .cyc_req  (cyc_req),
  .cyc_wr   (cyc_wr),
  .cyc_addr (cyc_addr),
  .busy     (busy),
  .done     (done)
);

// File: tb/pkt_xfer_engine_tb.sv
module pkt_xfer_engine_tb;
  localparam int LONG  = 16;
  localparam int SHORT = 8;
  localparam int AW    = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       len_long = 1'b0;
  logic       dir_in = 1'b0;
  logic [2:0] reg_sel = 3'd0;
  logic [AW-1:0] buf_addr;
  logic       buf_rd_en, buf_wr_en, cyc_req, cyc_wr, busy, done;
  logic [7:0] buf_rdata = 8'd0;
  logic [7:0] buf_wdata, cyc_wdata;
  logic [2:0] cyc_addr;
  logic       cyc_done = 1'b0;
  logic [7:0] cyc_rdata = 8'd0;

  always #2.5 clk = ~clk;

  pkt_xfer_engine #(.LONG_LEN(LONG), .SHORT_LEN(SHORT)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .len_long(len_long),
    .dir_in(dir_in), .reg_sel(reg_sel), .buf_addr(buf_addr),
    .buf_rd_en(buf_rd_en), .buf_rdata(buf_rdata), .buf_wr_en(buf_wr_en),
    .buf_wdata(buf_wdata), .cyc_req(cyc_req), .cyc_wr(cyc_wr),
    .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata), .cyc_done(cyc_done),
    .cyc_rdata(cyc_rdata), .busy(busy), .done(done)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * 37 + seed * 11 + 5) & 255);
  endfunction

  logic [7:0] out_mem [LONG];
  logic [7:0] in_mem  [LONG];

  // bench-side model state
  bit  mon_on = 1'b0;
  int  cyc = 0;
  int  exp_len = 0, exp_dir = 0, exp_reg = 0, seed = 0, lat = 1;
  int  n_req = 0, n_rd = 0, n_wr = 0;
  int  last_rd = -10, last_done = -10;
  bit  pend = 1'b0;
  int  cd = 0;
  bit  done_chk = 1'b0;

  always @(negedge clk) begin
    cyc++;
    cyc_done <= 1'b0;
    if (!rst_n || !mon_on) begin
      pend     = 1'b0;
      done_chk = 1'b0;
    end else begin
      if (done_chk) begin
        check(done == 1'b1 && busy == 1'b0, "R8 done after last byte", int'(done), 1);
        done_chk = 1'b0;
      end
      if (buf_rd_en) begin
        check(exp_dir == 0, "R3 read only outbound", exp_dir, 0);
        check(int'(buf_addr) == n_rd, "R2 R3 read address order", int'(buf_addr), n_rd);
        buf_rdata <= out_mem[buf_addr];
        last_rd = cyc;
        n_rd++;
      end
      if (buf_wr_en) begin
        check(exp_dir == 1, "R6 no buffer write outbound", 1, 0);
        check(int'(buf_addr) == n_wr, "R2 R7 write address order", int'(buf_addr), n_wr);
        check(cyc - last_done == 1, "R7 write one clock after done", cyc - last_done, 1);
        in_mem[buf_addr] = buf_wdata;
        n_wr++;
        if (n_wr == exp_len) done_chk = 1'b1;
      end
      if (pend) begin
        if (cd == 0) begin
          cyc_done <= 1'b1;
          cyc_rdata <= pat(n_req - 1, seed);
          last_done = cyc;
          pend = 1'b0;
          if (exp_dir == 0 && n_req == exp_len) done_chk = 1'b1;
        end else begin
          cd--;
        end
      end else if (cyc_req) begin
        check(int'(cyc_addr) == exp_reg, "R5 register address held", int'(cyc_addr), exp_reg);
        check(int'(cyc_wr) == 1 - exp_dir, "R10 cycle direction", int'(cyc_wr), 1 - exp_dir);
        if (exp_dir == 0) begin
          check(cyc_wdata == out_mem[n_req], "R3 outbound data", int'(cyc_wdata), int'(out_mem[n_req]));
          check(cyc - last_rd == 2, "R4 request after read", cyc - last_rd, 2);
        end
        n_req++;
        pend = 1'b1;
        cd = lat - 1;
      end
      if (pend && cyc_req && cd != lat - 1) check(1'b0, "R10 request before done", 1, 0);
    end
  end

  task automatic run_batch(input bit lng, input bit din, input int latency,
                           input int rsel, input bit mid_start);
    int len;
    bit seen;
    len = lng ? LONG : SHORT;
    seed++;
    for (int i = 0; i < LONG; i++) begin
      out_mem[i] = pat(i, seed + 100);
      in_mem[i]  = 8'hxx;
    end
    @(negedge clk);
    exp_len = len; exp_dir = int'(din); exp_reg = rsel; lat = latency;
    n_req = 0; n_rd = 0; n_wr = 0; last_rd = -10; last_done = -10;
    if (din == 1'b0) for (int i = 0; i < LONG; i++) out_mem[i] = pat(i, seed);
    mon_on = 1'b1;
    len_long = lng; dir_in = din; reg_sel = 3'(rsel); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    reg_sel = ~3'(rsel);
    len_long = ~lng;
    dir_in = ~din;
    check(busy == 1'b1 && done == 1'b0, "R8 start clears done", int'(done), 0);
    if (mid_start) begin
      while (n_req < 2) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    seen = 1'b0;
    for (int t = 0; t < 4000 && !seen; t++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    check(seen, "R8 batch completes", int'(seen), 1);
    check(n_req == len, "R1 R9 bus cycle count", n_req, len);
    if (din) begin
      check(n_wr == len, "R7 write count", n_wr, len);
      for (int i = 0; i < len; i++)
        check(in_mem[i] == pat(i, seed), "R7 inbound byte", int'(in_mem[i]), int'(pat(i, seed)));
    end else begin
      check(n_rd == len && n_wr == 0, "R3 R6 read/write counts", n_rd * 100 + n_wr, len * 100);
    end
    repeat (4) @(negedge clk);
    check(done == 1'b1 && busy == 1'b0, "R8 done holds", int'(done), 1);
    check(buf_rd_en == 0 && buf_wr_en == 0 && cyc_req == 0, "R10 quiet after batch", 1, 0);
    mon_on = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && buf_rd_en == 0 && buf_wr_en == 0 && cyc_req == 0 &&
          buf_addr == 0, "R2 reset state", int'(busy), 0);
    rst_n = 1'b1;
    for (int l = 0; l < 2; l++)
      for (int d = 0; d < 2; d++)
        for (int k = 1; k <= 3; k++)
          run_batch(l[0], d[0], k, (l * 3 + d * 2 + k) & 7, (k == 2));
    // asynchronous abort in the middle of a long outbound batch
    @(negedge clk);
    exp_len = LONG; exp_dir = 0; exp_reg = 5; lat = 2;
    n_req = 0; n_rd = 0; n_wr = 0; last_rd = -10;
    for (int i = 0; i < LONG; i++) out_mem[i] = pat(i, 77);
    mon_on = 1'b1;
    len_long = 1'b1; dir_in = 1'b0; reg_sel = 3'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (n_req < 3) @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    check(busy == 0 && buf_addr == 0 && done == 0 && cyc_req == 0 && buf_rd_en == 0,
          "R2 asynchronous clear", int'(buf_addr), 0);
    mon_on = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    run_batch(1'b0, 1'b1, 1, 6, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule